// File: doc/BRIEF.md
# Two-Stage Register Readback Responder

This block answers register reads on a serial slave interface that needs two frames for each read. A host first writes a register address into a dedicated readback-select register (address 0x13). During the frame that follows, usually a no-operation write of zeros to register 0x00, the block shifts a 32-bit response word out on its serial data output. The bits move in step with the host's serial clock.

The response word has five parts:
- a fixed two-bit header;
- the fault pin state;
- the selected register address;
- that register's 16-bit contents, taken from a register-read port;
- a CRC-8 over the first 24 bits.

Frame decoding happens upstream. The block receives decoded write strobes, the frame-select line and the serial clock, all already in its own clock domain. The output pad driver outside the block uses the output-enable signal to put the line into high impedance.

Internally a four-state controller runs each frame:
- **IDLE**: the frame-select line is high.
- **ARM**: the frame has started and bit 31 is presented.
- **SHIFT**: one bit advances per serial-clock rising edge.
- **DRAIN**: all 32 bits have been sent and zeros follow.

The transitions are:
- IDLE→ARM on the falling edge of frame select.
- ARM→SHIFT on the first serial-clock rise.
- SHIFT→DRAIN on the rise that presents bit 0.
- ARM, SHIFT or DRAIN→IDLE whenever frame select is high.

Top module: `rbk_resp_gen`

## Requirements
- R1: A write strobe with `wr_addr` = 0x13 latches `wr_data[4:0]` as the selected address, and `rd_addr` shows it from the next cycle.
- R2: Write strobes to any other address leave the selected address unchanged.
- R3: After reset the selected address is 0x00, `sdo_oe` is low and `sdo` is low.
- R4: The response word has the following fields:
  - bits 31:30: binary 10;
  - bit 29: the fault pin;
  - bits 28:24: the selected address;
  - bits 23:8: the selected register's data;
  - bits 7:0: the check byte.
- R5: The check byte is a CRC-8 over bits 31:8, MSB first, with polynomial x^8+x^2+x+1 (0x07) and initial value 0. Reading register 0x14 holding 0xA000 with the fault pin low yields 0x94A0001A.
- R6: Address, data and fault state are captured in the cycle where frame select is first seen low. Later changes do not alter the word being sent.
- R7: `sdo_oe` is low in the cycle after frame select is seen high. It rises in the cycle after frame select is first seen low.
- R8: Bit 31 is presented from frame start through the first serial-clock rise. Each later rise advances to the next lower bit, so the host samples bit 31−k on falling edge k+1.
- R9: After bit 0 has been presented, the next rise and all further rises in the frame drive `sdo` low.
- R10: Frame select going high aborts the frame at any point. The next frame restarts at bit 31 with a fresh capture.
- R11: A select write that arrives during a frame does not change the word in flight. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Frame select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock level, idles low, synchronous to clk |
| wr_stb | input | 1 | Decoded register write strobe |
| wr_addr | input | 5 | Decoded write register address |
| wr_data | input | 16 | Decoded write data |
| fault_in | input | 1 | Fault pin state |
| rd_addr | output | 5 | Register-read port address (selected register) |
| rd_data | input | 16 | Register-read port data for `rd_addr` |
| sdo | output | 1 | Serial response data |
| sdo_oe | output | 1 | Output enable for the serial data pad |

## Verification
The bench targets the following corner cases, each paired with how a faulty design would show it:
- **Bit 31 before the first serial-clock rise.** A responder that shifts on every rise would lose bit 31 entirely.
- **Register data or the fault pin changing mid-frame.** A design that reads the register port live would send a word with torn fields.
- **A select write arriving mid-frame.** A design that reads the select register live would switch address partway through the word.
- **Frames longer than 32 clocks.** These expose stale bits that keep recirculating after bit 0.
- **Aborted frames.** These expose a bit counter that is not re-armed at frame start.
- **The reset-state word for register 0x14.** Any wrong polynomial, bit order or field placement changes this word.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DRAIN = 2'd3
    } rbk_state_e;

    // Fixed response header placed in the two top bits
    localparam logic [1:0] RESP_HDR = 2'b10;

endpackage

// File: rtl/rbk_sel_reg.sv
module rbk_sel_reg #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] SEL_REG = 5'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] sel_addr
);

    logic hit;

    assign hit = wr_stb && (wr_addr == SEL_REG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_addr <= '0;
        end else if (hit) begin
            sel_addr <= wr_data[ADDR_W-1:0];
        end
    end

    // R1
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == SEL_REG) |=> (sel_addr == $past(wr_data[ADDR_W-1:0])));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == SEL_REG) |=> $stable(sel_addr));

endmodule

// File: rtl/rbk_crc8.sv
module rbk_crc8 #(
    parameter int IN_W = 24,
    parameter int CW = 8,
    parameter logic [CW-1:0] POLY = 8'h07
) (
    input  logic [IN_W-1:0] din,
    output logic [CW-1:0]   crc
);

    // One stage per input bit, MSB first
    logic [CW-1:0] stage [0:IN_W];

    assign stage[0] = '0;

    for (genvar i = 0; i < IN_W; i++) begin : g_step
        logic fb;
        assign fb = stage[i][CW-1] ^ din[IN_W-1-i];
        assign stage[i+1] = {stage[i][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc = stage[IN_W];

endmodule

// File: rtl/rbk_frame_fsm.sv
module rbk_frame_fsm
    import rbk_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic sclk,
    output logic load,
    output logic shift,
    output logic clear,
    output logic oe
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(FRAME_W - 2);

    rbk_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic sync_q, sclk_q;
    logic frame_start, sck_rise;

    assign frame_start = sync_q && !sync_n;
    assign sck_rise    = sclk && !sclk_q;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (frame_start) nxt = ST_ARM;
            ST_ARM:   if (sync_n) nxt = ST_IDLE;
                      else if (sck_rise) nxt = ST_SHIFT;
            ST_SHIFT: if (sync_n) nxt = ST_IDLE;
                      else if (sck_rise && cnt == LAST_SHIFT) nxt = ST_DRAIN;
            ST_DRAIN: if (sync_n) nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sync_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            state  <= nxt;
            sync_q <= sync_n;
            sclk_q <= sclk;
            if (load) begin
                cnt <= '0;
            end else if (shift) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        load  = (state == ST_IDLE) && frame_start;
        shift = (state == ST_SHIFT) && !sync_n && sck_rise;
        clear = (state == ST_DRAIN) && !sync_n && sck_rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe <= 1'b0;
        end else begin
            oe <= (nxt != ST_IDLE);
        end
    end

    // R9
    drain_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (cnt == CNT_W'(FRAME_W - 1)));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |=> (state == ST_IDLE));

endmodule

// File: rtl/rbk_shift_out.sv
module rbk_shift_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    input  logic         clear,
    output logic         bit_out
);

    logic [W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= word;
        end else if (clear) begin
            shreg <= '0;
        end else if (shift) begin
            shreg <= {shreg[W-2:0], 1'b0};
        end
    end

    assign bit_out = shreg[W-1];

endmodule

// File: rtl/rbk_resp_gen.sv
module rbk_resp_gen
    import rbk_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int CRC_W = 8,
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
    parameter logic [ADDR_W-1:0] SEL_REG = 5'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fault_in,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int BODY_W  = 3 + ADDR_W + DATA_W;
    localparam int FRAME_W = BODY_W + CRC_W;

    logic [ADDR_W-1:0]  sel_addr;
    logic [BODY_W-1:0]  body;
    logic [CRC_W-1:0]   chk;
    logic [FRAME_W-1:0] word;
    logic load, shift, clear, oe, bit_out;

    rbk_sel_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_REG(SEL_REG)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_addr(sel_addr)
    );

    assign rd_addr = sel_addr;
    assign body    = {RESP_HDR, fault_in, sel_addr, rd_data};

    rbk_crc8 #(
        .IN_W(BODY_W),
        .CW  (CRC_W),
        .POLY(CRC_POLY)
    ) u_crc (
        .din(body),
        .crc(chk)
    );

    assign word = {body, chk};

    rbk_frame_fsm #(
        .FRAME_W(FRAME_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_n(sync_n),
        .sclk  (sclk),
        .load  (load),
        .shift (shift),
        .clear (clear),
        .oe    (oe)
    );

    rbk_shift_out #(
        .W(FRAME_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .word   (word),
        .shift  (shift),
        .clear  (clear),
        .bit_out(bit_out)
    );

    assign sdo    = oe && bit_out;
    assign sdo_oe = oe;

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |=> !sdo_oe);

    // R4
    hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdo_oe && sdo));

endmodule

// File: tb/rbk_resp_gen_tb_top.sv
module rbk_resp_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1;
    logic sclk = 1'b0;
    logic wr_stb = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic fault_in = 1'b0;
    logic [4:0] rd_addr;
    logic [15:0] rd_data;
    logic sdo, sdo_oe;

    logic [15:0] regs [0:31];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign rd_data = regs[rd_addr];

    rbk_resp_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_in(fault_in), .rd_addr(rd_addr), .rd_data(rd_data),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [7:0] ref_crc(input logic [23:0] v);
        logic [7:0] c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            logic top = c[7] ^ v[i];
            c = {c[6:0], 1'b0};
            if (top) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_word(input logic [4:0] a, input logic [15:0] d, input logic f);
        logic [23:0] b = {2'b10, f, a, d};
        return {b, ref_crc(b)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle reference model
    int m_sel = 0;
    bit m_sync_q = 1, m_sclk_q = 0, m_active = 0;
    int m_rises = 0, m_pos = 31;
    logic [31:0] m_word = '0;
    bit model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_sync_q = 1; m_sclk_q = 0; m_active = 0;
        end else begin
            if (sync_n) begin
                m_active = 0;
            end else if (m_sync_q && !m_active) begin
                m_word = ref_word(5'(m_sel), regs[m_sel], fault_in);
                m_active = 1; m_rises = 0; m_pos = 31;
            end else if (m_active && sclk && !m_sclk_q) begin
                m_rises++;
                if (m_rises >= 2) m_pos--;
            end
            if (wr_stb && wr_addr == 5'h13) m_sel = int'(wr_data[4:0]);
            m_sync_q = sync_n;
            m_sclk_q = sclk;
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R1 rd_addr", {27'b0, rd_addr}, 32'(m_sel));
            check("R7 sdo_oe", {31'b0, sdo_oe}, {31'b0, m_active});
            check("R8 sdo", {31'b0, sdo},
                  {31'b0, (m_active && m_pos >= 0) ? m_word[m_pos] : 1'b0});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_stb = 1'b0;
    endtask

    // evt: 0 none, 1 mutate data and fault, 2 select write to 0x02
    task automatic frame(input int nbits, input int evt_at, input int evt, output logic [31:0] got);
        got = '0;
        sync_n = 1'b0;
        tick(2);
        for (int i = 0; i < nbits; i++) begin
            if (i == evt_at && evt == 1) begin
                for (int r = 0; r < 32; r++) regs[r] = ~regs[r];
                fault_in = ~fault_in;
            end
            if (i == evt_at && evt == 2) wr(5'h13, 16'h0002);
            sclk = 1'b1; tick(2);
            sclk = 1'b0; tick(2);
            @(negedge clk);
            if (i < 32) got[31-i] = sdo;
            else check("R9 trailing bit", {31'b0, sdo}, 32'h0);
        end
        tick(2);
        sync_n = 1'b1;
        tick(3);
        check("R7 idle oe", {31'b0, sdo_oe}, 32'h0);
    endtask

    initial begin
        logic [31:0] got, exp;
        for (int r = 0; r < 32; r++) regs[r] = 16'h1000 + 16'(r * 16'h0101);
        regs[20] = 16'hA000;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        model_on = 1;
        // R3 reset state
        check("R3 rd_addr", {27'b0, rd_addr}, 32'h0);
        check("R3 sdo_oe", {31'b0, sdo_oe}, 32'h0);
        check("R3 sdo", {31'b0, sdo}, 32'h0);

        // R3/R4: default selection is register 0
        frame(32, -1, 0, got);
        check("R3 R4 default word", got, ref_word(5'h00, regs[0], 1'b0));

        // R1/R5: select 0x14, known word
        wr(5'h13, 16'h0014);
        check("R1 select", {27'b0, rd_addr}, 32'h14);
        frame(32, -1, 0, got);
        check("R5 known word", got, 32'h94A0001A);

        // R4: fault bit
        fault_in = 1'b1;
        frame(32, -1, 0, got);
        check("R4 fault word", got, ref_word(5'h14, 16'hA000, 1'b1));
        fault_in = 1'b0;

        // R2: other addresses ignored
        wr(5'h08, 16'h15FA);
        wr(5'h00, 16'h0000);
        check("R2 hold", {27'b0, rd_addr}, 32'h14);
        frame(32, -1, 0, got);
        check("R2 word", got, 32'h94A0001A);

        // R4/R5: extreme data patterns
        regs[31] = 16'hFFFF;
        wr(5'h13, 16'hFFFF);
        frame(32, -1, 0, got);
        check("R4 R5 all-ones", got, ref_word(5'h1F, 16'hFFFF, 1'b0));
        regs[1] = 16'h0000;
        wr(5'h13, 16'h0001);
        frame(32, -1, 0, got);
        check("R5 zero data", got, ref_word(5'h01, 16'h0000, 1'b0));

        // R8: bit 31 before the first rise
        sync_n = 1'b0;
        tick(2);
        @(negedge clk);
        check("R8 first bit", {31'b0, sdo}, 32'h1);
        tick(1);
        sync_n = 1'b1;
        tick(3);

        // R6: mid-frame data and fault changes ignored
        exp = ref_word(5'h01, regs[1], fault_in);
        frame(32, 8, 1, got);
        check("R6 capture", got, exp);
        check("R6 next frame", {27'b0, rd_addr}, 32'h01);
        exp = ref_word(5'h01, regs[1], fault_in);
        frame(32, -1, 0, got);
        check("R6 new data", got, exp);

        // R9: overlong frame trails zeros
        frame(40, -1, 0, got);
        check("R9 word", got, exp);

        // R10: abort then restart
        frame(10, -1, 0, got);
        check("R10 partial", got & 32'hFFC0_0000, exp & 32'hFFC0_0000);
        frame(32, -1, 0, got);
        check("R10 restart", got, exp);

        // R11: select write during frame
        frame(32, 5, 2, got);
        check("R11 in flight", got, exp);
        frame(32, -1, 0, got);
        check("R11 following", got, ref_word(5'h02, regs[2], fault_in));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule